// File: doc/BRIEF.md
# Uncorrectable Error Header Logger

This block records the transaction header behind the first uncorrectable error that is not masked, and keeps that record until software has cleared every uncorrectable status bit. Error events arrive as a vector of error bits qualified by a valid strobe. A 16-byte header comes with them, together with a flag that tells a 4-DW header from a 3-DW one. A per-bit mask input stops individual error sources from logging, from moving the first-error pointer and from being reported.

Software uses a small register port. It can read four 32-bit log words, the status register and the pointer to the first error. Writing ones to the status register clears those bits. Once every status bit is zero, the logger is armed again. The next unmasked error then captures a fresh header and a fresh pointer, so software can tell a new event from the old one by a change in the pointer.

The log words, the status register and the pointer are sticky. Only the power-on reset clears them. The ordinary reset clears only the report pulse. Error events have a valid strobe but no ready: the block accepts an event on every cycle, so it never applies back-pressure, and a source must not hold a valid event for more than one cycle unless it means it to count again.

Top module: `ue_hdr_logger`

## Requirements
- R1: The first unmasked error seen while all status bits are zero captures the header into the log words. While any status bit is set, the log words and the pointer do not change.
- R2: The log is rearmed only when the status register reads all zeros. Clearing just some of the set bits leaves it locked.
- R3: Header byte b (hdr_in bits 8b+7:8b) is stored in log word b/4, at bits 31-8*(b%4) down to 24-8*(b%4). Byte 0 therefore lands in bits 31:24 of word 0.
- R4: When a 3-DW header is captured (hdr_full=0), log word 3 reads zero.
- R5: An error whose mask bit is 1 sets no status bit, leaves the pointer unchanged, causes no capture and causes no report.
- R6: Every unmasked error sets its status bit, whether the log is locked or not. Writing to address 4 clears the status bits where the write data holds ones. A set and a clear of the same bit in one cycle leave the bit set.
- R7: The pointer holds the index of the lowest unmasked error bit in the capturing cycle. It changes only on a capture.
- R8: Writes to log-word addresses 0 to 3 and to the pointer address 5 have no effect.
- R9: The ordinary reset (rst_n low) keeps the log words, status and pointer, and forces err_report to 0.
- R10: The power-on reset (por_n low) clears the log words, status, pointer and err_report to zero.
- R11: err_report is high for one cycle, in the cycle after any cycle that carries at least one unmasked error.
- R12: reg_rdata is a combinational read of the register selected by reg_addr: 0 to 3 select the log words, 4 selects status, 5 selects the pointer zero-extended, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears sticky state |
| rst_n | input | 1 | Ordinary reset, active low, synchronous; clears the report only |
| err_valid | input | 1 | Qualifies err_bits and the header |
| err_bits | input | 32 | Uncorrectable error sources raised this cycle |
| err_mask | input | 32 | 1 = source masked |
| hdr_in | input | 128 | Header bytes, byte b at bits 8b+7:8b |
| hdr_full | input | 1 | 1 = 4-DW header, 0 = 3-DW header |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data (write-one-to-clear at address 4) |
| reg_rdata | output | 32 | Read data for reg_addr |
| err_report | output | 1 | Report pulse toward the root complex |

## Verification
The assertions check on every cycle that the log and the pointer stay frozen while any status bit is set, that masked traffic leaves the pointer and the report untouched, that every unmasked bit reaches status, that a 3-DW capture leaves word 3 at zero, and that the ordinary reset leaves the sticky state alone. Other properties can only be shown by the bench's scenarios. These are the byte placement inside the words, which of several simultaneous errors wins the pointer, rearming only after a full clear (versus a partial one), the lost capture when a clear and a new error arrive together, and the difference between the two resets.

// File: rtl/ue_log_pkg.sv
package ue_log_pkg;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] RA_LOG0 = 3'd0;
  localparam logic [ADDR_W-1:0] RA_LOG3 = 3'd3;
  localparam logic [ADDR_W-1:0] RA_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] RA_PTR  = 3'd5;
endpackage

// File: rtl/ue_err_status.sv
module ue_err_status #(
  parameter int unsigned NERR = 32
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            err_valid,
  input  logic [NERR-1:0] err_bits,
  input  logic [NERR-1:0] err_mask,
  input  logic [NERR-1:0] clr_bits,
  output logic [NERR-1:0] unmasked,
  output logic [NERR-1:0] status_q,
  output logic            report_q
);
  assign unmasked = err_valid ? (err_bits & ~err_mask) : '0;

  // sticky: only power-on reset clears; a set beats a clear in one cycle
  always_ff @(posedge clk) begin
    if (!por_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_bits) | unmasked;
  end

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) report_q <= 1'b0;
    else                  report_q <= |unmasked;
  end
endmodule

// File: rtl/ue_hdr_capture.sv
module ue_hdr_capture #(
  parameter int unsigned NERR   = 32,
  parameter int unsigned NWORDS = 4,
  parameter int unsigned SHORTW = 3,
  localparam int unsigned PTR_W  = $clog2(NERR),
  localparam int unsigned HDR_W  = NWORDS * 32
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             capture,
  input  logic [NERR-1:0]  unmasked,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             hdr_full,
  output logic [HDR_W-1:0] log_flat,
  output logic [PTR_W-1:0] ptr_q
);
  logic [HDR_W-1:0] packed_hdr;
  logic [PTR_W-1:0] low_idx;

  // big-endian byte placement within each word
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    for (genvar k = 0; k < 4; k++) begin : g_byte
      if (w >= SHORTW) begin : g_tail
        assign packed_hdr[w*32 + 31 - 8*k -: 8] =
          hdr_full ? hdr_in[8*(4*w + k) +: 8] : 8'h00;
      end else begin : g_head
        assign packed_hdr[w*32 + 31 - 8*k -: 8] = hdr_in[8*(4*w + k) +: 8];
      end
    end
  end

  always_comb begin
    low_idx = '0;
    for (int i = NERR - 1; i >= 0; i--) begin
      if (unmasked[i]) low_idx = PTR_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      log_flat <= '0;
      ptr_q    <= '0;
    end else if (capture) begin
      log_flat <= packed_hdr;
      ptr_q    <= low_idx;
    end
  end
endmodule

// File: rtl/ue_reg_read.sv
module ue_reg_read
  import ue_log_pkg::*;
#(
  parameter int unsigned NERR   = 32,
  parameter int unsigned NWORDS = 4,
  localparam int unsigned PTR_W = $clog2(NERR)
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [NWORDS*32-1:0]   log_flat,
  input  logic [NERR-1:0]        status_q,
  input  logic [PTR_W-1:0]       ptr_q,
  output logic [REG_DW-1:0]      rdata
);
  always_comb begin
    rdata = '0;
    if (addr <= RA_LOG3 && int'(addr) < NWORDS) rdata = log_flat[int'(addr)*32 +: 32];
    else if (addr == RA_STAT) rdata = REG_DW'(status_q);
    else if (addr == RA_PTR)  rdata = REG_DW'(ptr_q);
  end
endmodule

// File: rtl/ue_hdr_logger.sv
module ue_hdr_logger
  import ue_log_pkg::*;
#(
  parameter int unsigned NERR   = 32,
  parameter int unsigned NWORDS = 4,
  localparam int unsigned PTR_W = $clog2(NERR),
  localparam int unsigned HDR_W = NWORDS * 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              err_valid,
  input  logic [NERR-1:0]   err_bits,
  input  logic [NERR-1:0]   err_mask,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic              hdr_full,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              err_report
);
  logic [NERR-1:0]  unmasked;
  logic [NERR-1:0]  status_q;
  logic [NERR-1:0]  clr_bits;
  logic [HDR_W-1:0] log_flat;
  logic [PTR_W-1:0] ptr_q;
  logic             capture;

  assign clr_bits = (reg_wr && reg_addr == RA_STAT) ? reg_wdata[NERR-1:0] : '0;
  // locked whenever any status bit is set
  assign capture  = (|unmasked) && (status_q == '0);

  ue_err_status #(.NERR(NERR)) u_status (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .err_valid(err_valid),
    .err_bits(err_bits), .err_mask(err_mask), .clr_bits(clr_bits),
    .unmasked(unmasked), .status_q(status_q), .report_q(err_report)
  );

  ue_hdr_capture #(.NERR(NERR), .NWORDS(NWORDS)) u_capture (
    .clk(clk), .por_n(por_n), .capture(capture), .unmasked(unmasked),
    .hdr_in(hdr_in), .hdr_full(hdr_full), .log_flat(log_flat), .ptr_q(ptr_q)
  );

  ue_reg_read #(.NERR(NERR), .NWORDS(NWORDS)) u_read (
    .addr(reg_addr), .log_flat(log_flat), .status_q(status_q),
    .ptr_q(ptr_q), .rdata(reg_rdata)
  );
endmodule

// File: rtl/ue_hdr_logger_chk.sv
module ue_hdr_logger_chk #(
  parameter int unsigned NERR   = 32,
  parameter int unsigned NWORDS = 4,
  parameter int unsigned PTR_W  = 5
) (
  input logic                 clk,
  input logic                 por_n,
  input logic                 rst_n,
  input logic                 err_valid,
  input logic [NERR-1:0]      err_bits,
  input logic [NERR-1:0]      err_mask,
  input logic                 hdr_full,
  input logic                 err_report,
  input logic [NWORDS*32-1:0] log_flat,
  input logic [NERR-1:0]      status_q,
  input logic [PTR_W-1:0]     ptr_q
);
  logic [NERR-1:0] um;
  assign um = err_valid ? (err_bits & ~err_mask) : '0;

  p_log_frozen_r1: assert property (@(posedge clk) disable iff (!por_n)
    (status_q != '0) |=> ($stable(log_flat) && $stable(ptr_q)));

  p_masked_ptr_r5: assert property (@(posedge clk) disable iff (!por_n)
    (um == '0) |=> $stable(ptr_q));

  p_masked_report_r5: assert property (@(posedge clk) disable iff (!por_n)
    (um == '0) |=> !err_report);

  p_status_set_r6: assert property (@(posedge clk) disable iff (!por_n)
    (um != '0) |=> ((status_q & $past(um)) == $past(um)));

  p_short_tail_r4: assert property (@(posedge clk) disable iff (!por_n)
    ((um != '0) && (status_q == '0) && !hdr_full) |=> (log_flat[NWORDS*32-1 -: 32] == '0));

  p_soft_reset_keeps_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_n && !err_valid) |=> ($stable(log_flat) && $stable(ptr_q) && !err_report));
endmodule

bind ue_hdr_logger ue_hdr_logger_chk #(.NERR(NERR), .NWORDS(NWORDS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .err_valid(err_valid),
  .err_bits(err_bits), .err_mask(err_mask), .hdr_full(hdr_full),
  .err_report(err_report), .log_flat(log_flat), .status_q(status_q), .ptr_q(ptr_q)
);

// File: tb/ue_hdr_logger_tb.sv
module ue_hdr_logger_tb;
  logic         clk = 1'b0;
  logic         por_n, rst_n, err_valid, hdr_full, reg_wr, err_report;
  logic [31:0]  err_bits, err_mask, reg_wdata, reg_rdata;
  logic [127:0] hdr_in;
  logic [2:0]   reg_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [31:0] m_log [4];
  logic [31:0] m_stat;
  logic [4:0]  m_ptr;
  logic        m_rep;

  ue_hdr_logger u_dut (.*);

  always #10 clk = ~clk;

  function automatic logic [31:0] pack_word(logic [127:0] h, int w, logic full);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[31-8*k -: 8] = h[8*(4*w+k) +: 8];
    if (w == 3 && !full) r = '0;
    return r;
  endfunction

  function automatic logic [4:0] lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 5'(i);
    return 5'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, string req, logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic check_all(string req);
    for (int w = 0; w < 4; w++) rd(3'(w), req, m_log[w]);
    rd(3'd4, req, m_stat);
    rd(3'd5, req, {27'd0, m_ptr});
    check({req, " report"}, {31'd0, err_report}, {31'd0, m_rep});
  endtask

  // one clock with the given stimulus; model updated after the edge
  task automatic step(logic ev, logic [31:0] bits, logic [31:0] msk,
                      logic [127:0] h, logic full, logic wr,
                      logic [2:0] a, logic [31:0] wd);
    logic [31:0] um, clr;
    @(negedge clk);
    err_valid = ev; err_bits = bits; err_mask = msk; hdr_in = h; hdr_full = full;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk); #1;
    um  = ev ? (bits & ~msk) : 32'd0;
    clr = (wr && a == 3'd4) ? wd : 32'd0;
    if (!por_n) begin
      for (int w = 0; w < 4; w++) m_log[w] = '0;
      m_stat = '0; m_ptr = '0; m_rep = 1'b0;
    end else begin
      if (um != 0 && m_stat == 0) begin
        for (int w = 0; w < 4; w++) m_log[w] = pack_word(h, w, full);
        m_ptr = lowest(um);
      end
      m_stat = (m_stat & ~clr) | um;
      m_rep  = rst_n ? (um != 0) : 1'b0;
    end
    err_valid = 0; reg_wr = 0;
  endtask

  function automatic logic [127:0] seq_hdr(logic [7:0] base);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = base + 8'(b);
    return r;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] h;
    void'($urandom(32'h5eed_1234));
    por_n = 0; rst_n = 0; err_valid = 0; err_bits = 0; err_mask = 0;
    hdr_in = 0; hdr_full = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    for (int w = 0; w < 4; w++) m_log[w] = '0;
    m_stat = 0; m_ptr = 0; m_rep = 0;
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0);
    por_n = 1; rst_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R10 reset state");

    // R3 byte order and R1 capture, R11 report
    h = seq_hdr(8'h00);
    step(1, 32'h80, 0, h, 1, 0, 0, 0);
    check("R3 word0", m_log[0], 32'h00010203);
    check("R3 word3", m_log[3], 32'h0c0d0e0f);
    check_all("R1 R3 R7 R11 first capture");
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R11 pulse ends");

    // locked: second error sets status only (R1, R6)
    step(1, 32'h8, 0, seq_hdr(8'h40), 1, 0, 0, 0);
    check_all("R1 R6 locked");

    // masked error (R5)
    step(1, 32'h200, 32'h200, seq_hdr(8'h80), 1, 0, 0, 0);
    check_all("R5 masked");

    // writes to log and pointer ignored (R8)
    step(0, 0, 0, 0, 0, 1, 3'd0, 32'hffffffff);
    step(0, 0, 0, 0, 0, 1, 3'd5, 32'hffffffff);
    check_all("R8 read-only");
    rd(3'd7, "R12 unused addr", 32'd0);

    // partial clear keeps lock (R2)
    step(0, 0, 0, 0, 0, 1, 3'd4, 32'h80);
    step(1, 32'h2, 0, seq_hdr(8'h20), 1, 0, 0, 0);
    check_all("R2 partial clear");

    // clear and set same bit together: set wins (R6)
    step(1, 32'h2, 0, seq_hdr(8'h20), 1, 1, 3'd4, 32'h2);
    check_all("R6 set beats clear");

    // full clear rearms; 3-DW header with two errors (R2 R4 R7)
    step(0, 0, 0, 0, 0, 1, 3'd4, 32'hffffffff);
    check_all("R2 cleared");
    step(1, 32'h1020, 0, seq_hdr(8'ha0), 0, 0, 0, 0);
    check("R4 word3 zero", m_log[3], 32'd0);
    check("R7 lowest", {27'd0, m_ptr}, 32'd5);
    check_all("R2 R4 R7 rearmed capture");

    // ordinary reset (R9)
    rst_n = 0;
    step(1, 32'h4, 0, seq_hdr(8'h10), 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R9 ordinary reset");
    rst_n = 1;

    // power-on reset (R10)
    por_n = 0;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    por_n = 1;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check_all("R10 power-on");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [31:0] bits, msk, wd;
      bits = 32'd1 << ($urandom % 32);
      if ($urandom % 4 == 0) bits |= 32'd1 << ($urandom % 32);
      msk = ($urandom % 3 == 0) ? $urandom : 32'd0;
      wd  = ($urandom % 2) ? $urandom : 32'hffffffff;
      h = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 3) == 0, bits, msk, h, 1'($urandom), ($urandom % 4) == 0,
           ($urandom % 2) ? 3'd4 : 3'($urandom), wd);
      check_all("R1 R5 R6 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule